// File: doc/BRIEF.md
# Composite Memory Select Generator

This block merges up to four active-low memory-select strobes into one extra active-low chip select. The four sources are the program-memory, data-memory, boot-memory and I/O-space selects, and a 4-bit enable register chooses which of them take part. The composite output goes low in the same cycle as any enabled source that is low. It passes through no register, so it keeps the timing of the strobes that drive it.

A typical use is one external memory shared by the program and data spaces. Software enables both the program and the data bits, ties the memory's chip select to the composite output, and uses one of the individual selects as an additional address line. The enable register is loaded through a simple write port and can always be read back. The reset default enables every source except boot.

Top module: `cms_top`

## Requirements
- R1: After reset the enable register reads back 4'b1011. Bit 0 is program, bit 1 is data, bit 2 is boot and bit 3 is I/O.
- R2: With the program bit (bit 0) enabled, driving only `sel_n[0]` low drives `comp_sel_n` low.
- R3: With reset defaults, driving only the boot select `sel_n[2]` low leaves `comp_sel_n` high.
- R4: When `wr_en` is high at a rising clock edge, `en_rd` equals `wr_data` from that edge onward. Without `wr_en`, the register holds its value.
- R5: When the enable value is 4'b0000, `comp_sel_n` stays high for every pattern on `sel_n`.
- R6: `comp_sel_n` follows a change on `sel_n` in the same cycle, with no clock edge between them.
- R7: `comp_sel_n` is low exactly when at least one source is low on `sel_n` and its enable bit is 1. Otherwise it is high.
- R8: With only bits 0 and 1 enabled, either the program select or the data select drives `comp_sel_n` low, while the boot and I/O selects do not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Enable-register write strobe |
| wr_data | input | 4 | New enable value |
| sel_n | input | 4 | Active-low source selects: [0] program, [1] data, [2] boot, [3] I/O |
| comp_sel_n | output | 1 | Active-low composite select |
| en_rd | output | 4 | Enable register readback |

## Verification
A wrong stored enable bit appears on `en_rd` at the first sample after the write or reset that caused it. It also shows on `comp_sel_n` as soon as the matching source strobe is driven low. A gating fault, such as a wrong polarity or a missing or extra source, shows on `comp_sel_n` in the same cycle as the strobe pattern that exposes it. For that reason the bench compares both outputs against its model on every clock, using one-hot, multi-source and all-idle strobe patterns.

// File: rtl/cms_pkg.sv
package cms_pkg;
  localparam int unsigned NUM_SRC  = 4;
  localparam int unsigned SRC_PM   = 0;
  localparam int unsigned SRC_DM   = 1;
  localparam int unsigned SRC_BOOT = 2;
  localparam int unsigned SRC_IO   = 3;
  localparam logic [NUM_SRC-1:0] EN_RESET = 4'b1011;
  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/cms_rst_sync.sv
module cms_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cms_en_reg.sv
module cms_en_reg
  import cms_pkg::*;
#(
  parameter src_vec_t RESET_VAL = EN_RESET
) (
  input  logic     clk,
  input  logic     rst_sync_n,
  input  logic     wr_en,
  input  src_vec_t wr_data,
  output src_vec_t en_q
);
  src_vec_t en_d;

  always_comb begin
    en_d = en_q;
    if (wr_en) en_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) en_q <= RESET_VAL;
    else if (wr_en)  en_q <= en_d;
  end
endmodule

// File: rtl/cms_combine.sv
module cms_combine
  import cms_pkg::*;
(
  input  src_vec_t en,
  input  src_vec_t sel_n,
  output logic     comp_n
);
  src_vec_t hit;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign hit[g] = en[g] & ~sel_n[g];
  end

  assign comp_n = ~(|hit);
endmodule

// File: rtl/cms_top.sv
module cms_top
  import cms_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] wr_data,
  input  logic [3:0] sel_n,
  output logic       comp_sel_n,
  output logic [3:0] en_rd
);
  logic     rst_sync_n;
  src_vec_t en_q;

  cms_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  cms_en_reg #(.RESET_VAL(EN_RESET)) u_reg (
    .clk(clk), .rst_sync_n(rst_sync_n), .wr_en(wr_en),
    .wr_data(wr_data), .en_q(en_q)
  );

  cms_combine u_comb (
    .en(en_q), .sel_n(sel_n), .comp_n(comp_sel_n)
  );

  assign en_rd = en_q;

  // R1: the first cycle out of reset holds the default mask
  assert_reset_default_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sync_n && !$past(rst_sync_n)) |-> (en_q == EN_RESET));

  // R4: a write lands on the next edge; no write means no change
  assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en |=> (en_q == $past(wr_data)));
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !wr_en |=> $stable(en_q));

  // R5: no enabled source, no composite select
  assert_all_off_high_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en_q == '0) |-> comp_sel_n);

  // R3: boot strobe alone is ignored when its enable is clear
  assert_boot_masked_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!en_q[SRC_BOOT] && sel_n == 4'b1011) |-> comp_sel_n);

  // R7: idle strobes never produce a composite select
  assert_idle_high_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sel_n == 4'b1111) |-> comp_sel_n);
endmodule

// File: tb/cms_top_tb_top.sv
module cms_top_tb_top;
  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [3:0] wr_data;
  logic [3:0] sel_n;
  logic       comp_sel_n;
  logic [3:0] en_rd;

  int checks = 0;
  int errors = 0;
  logic [3:0] en_m;
  bit done = 0;

  cms_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .sel_n(sel_n), .comp_sel_n(comp_sel_n), .en_rd(en_rd)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // reference: enable register, writes only used well after reset release
  always @(posedge clk) begin
    if (!rst_n)     en_m <= 4'b1011;
    else if (wr_en) en_m <= wr_data;
  end

  function automatic logic ref_comp(input logic [3:0] en, input logic [3:0] s);
    logic r;
    r = 1'b1;
    for (int i = 0; i < 4; i++) if (en[i] && !s[i]) r = 1'b0;
    return r;
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // drive strobes at a negedge and compare a little later in the same cycle
  task automatic drive(input string req, input logic [3:0] s);
    @(negedge clk);
    sel_n = s;
    #1;
    check({req, " comp"}, {3'b0, comp_sel_n}, {3'b0, ref_comp(en_m, s)});
    check({req, " rd"}, en_rd, en_m);
  endtask

  task automatic write(input logic [3:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    check("R4 write", en_rd, v);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; sel_n = 4'hF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check("R1 reset", en_rd, 4'b1011);
    check("R7 idle", {3'b0, comp_sel_n}, 4'b0001);

    drive("R2", 4'b1110);
    check("R2 low", {3'b0, comp_sel_n}, 4'b0000);
    drive("R3", 4'b1011);
    check("R3 high", {3'b0, comp_sel_n}, 4'b0001);
    drive("R6", 4'b0111);
    check("R6 same cycle", {3'b0, comp_sel_n}, 4'b0000);
    drive("R7", 4'b1111);

    write(4'b0000);
    for (int p = 0; p < 16; p++) begin
      drive("R5", p[3:0]);
      check("R5 high", {3'b0, comp_sel_n}, 4'b0001);
    end

    write(4'b0011);
    drive("R8 pm", 4'b1110);
    drive("R8 dm", 4'b1101);
    drive("R8 boot", 4'b1011);
    drive("R8 io", 4'b0111);

    write(4'b0100);
    drive("R3 boot on", 4'b1011);
    check("R3 boot on low", {3'b0, comp_sel_n}, 4'b0000);

    // hold with no write for several cycles
    repeat (3) drive("R4 hold", 4'b1111);
    check("R4 hold", en_rd, 4'b0100);

    for (int e = 0; e < 16; e++) begin
      write(e[3:0]);
      for (int p = 0; p < 16; p++) drive("R7", p[3:0]);
    end

    // reset again restores the default
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); #1;
    check("R1 re-reset", en_rd, 4'b1011);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    drive("R1 after", 4'b1011);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule